// File: doc/BRIEF.md
# Video-Memory Contention Delay Generator

This block tells a CPU model how many wait T-states each memory access costs when it competes with the video fetch for display RAM. It runs its own per-frame T-state counter and raises a frame-start marker each time that counter returns to zero. On every clock it looks at the access address, the upper-RAM bank number, the memory-request flag and a machine-mode select. One cycle later it presents a contended flag and a delay of 0 to 6 T-states.

Delays follow a repeating eight-step ramp (6,5,4,3,2,1,0,0) across the first 128 T-states of each of 192 display lines. They are zero in the rest of each line and outside the display area. Three machine modes are supported.
- The early mode uses a 224 T-state line. Its start T-state can be moved by one through a parameter.
- The banked mode uses a 228 T-state line. It adds contention for odd banks paged into the top 16 KiB.
- The gate-array mode shares the banked timing and bank rules. It contends only for accesses that carry a memory request.

Top module: `vid_contention`

## Requirements
- R1: `tstate` counts up by one per clock from 0 to LEN-1 and then wraps to 0. LEN is 69888 when `mode` is 2'b00 and 70908 for any other `mode`. Reset sets it to 0.
- R2: `frame_start` is 1 exactly when `tstate` is 0.
- R3: An access counts as contended in two cases. First, in every mode, when `addr[15:14]` is 2'b01. Second, when `addr[15:14]` is 2'b11, `bank[0]` is 1 (banks 1, 3, 5, 7) and `mode` is not 2'b00. No other address is contended, and in mode 2'b00 the top 16 KiB never is.
- R4: When `mode[1]` is 1 (gate-array mode; 2'b11 acts the same as 2'b10), an access with `mreq` low gives `contended`=0 and `wait_ts`=0. In modes 2'b00 and 2'b01, `mreq` has no effect.
- R5: Let D be T minus the start T-state. At a contended T-state where D mod the line period is below 128, and the line index D / period is below 192, `wait_ts` is 6,5,4,3,2,1,0,0 for (D mod 8) = 0..7.
- R6: The start T-state is 14335 in mode 2'b00, or 14336 when parameter LATE_START is 1, and 14361 in the other modes. The line period is 224 in mode 2'b00 and 228 otherwise.
- R7: `wait_ts` is 0 before the start T-state, in the last 96 (or 100) T-states of each line, and after the 192nd display line until the frame wraps.
- R8: `contended` and `wait_ts` are registered. They describe the inputs and the `tstate` value present at the previous rising edge. Reset clears both.
- R9: `wait_ts` is 0 whenever `contended` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 early, 01 banked, 10/11 gate-array |
| addr | input | 16 | CPU access address |
| bank | input | 3 | Bank currently paged at 0xC000 |
| mreq | input | 1 | Access is a memory request |
| tstate | output | 17 | T-state within the frame |
| frame_start | output | 1 | Interrupt marker, high at T-state 0 |
| contended | output | 1 | Previous access hit contended memory |
| wait_ts | output | 3 | Wait T-states for the previous access |

## Verification
On every cycle, the assertions check the following:
- The counter steps by one and wraps.
- The delay never exceeds 6.
- The delay is zero when the access is not contended, and before the start T-state.
- The gate-array mode clears the flag when `mreq` is low.
- The early mode never contends the top 16 KiB.

Only the bench's full-frame sweeps can show where the ramp sits. That covers the exact start T-state in each mode and under both start options, the 128/96 and 128/100 line split, the end after 192 lines, and the per-bank decode. The sweeps compare each cycle against a behavioural reference that works from division and modulo of the T-state.

// File: rtl/vid_contention.sv
module vid_contention #(
  parameter bit LATE_START = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode,
  input  logic [15:0] addr,
  input  logic [2:0]  bank,
  input  logic        mreq,
  output logic [16:0] tstate,
  output logic        frame_start,
  output logic        contended,
  output logic [2:0]  wait_ts
);
  localparam int EARLY_LEN = 69888;
  localparam int BANK_LEN  = 70908;
  localparam int EARLY_PER = 224;
  localparam int BANK_PER  = 228;
  localparam int EARLY_ST  = 14335 + int'(LATE_START);
  localparam int BANK_ST   = 14361;
  localparam int ACTIVE    = 128;
  localparam int LINES     = 192;

  logic [16:0] cnt;
  logic [7:0]  col;
  logic [8:0]  row;

  logic early, gate;
  assign early = (mode == 2'b00);
  assign gate  = mode[1];

  logic [16:0] len_m1, start;
  logic [7:0]  per_m1, col0;
  logic [8:0]  row0;
  assign len_m1 = early ? 17'(EARLY_LEN - 1) : 17'(BANK_LEN - 1);
  assign per_m1 = early ? 8'(EARLY_PER - 1) : 8'(BANK_PER - 1);
  assign start  = early ? 17'(EARLY_ST) : 17'(BANK_ST);
  assign col0   = early ? 8'(EARLY_ST % EARLY_PER) : 8'(BANK_ST % BANK_PER);
  assign row0   = early ? 9'(EARLY_ST / EARLY_PER) : 9'(BANK_ST / BANK_PER);

  always_ff @(posedge clk) begin
    if (!rst_n || cnt == len_m1) begin
      cnt <= '0;
      col <= '0;
      row <= '0;
    end else begin
      cnt <= cnt + 17'd1;
      if (col == per_m1) begin
        col <= '0;
        row <= row + 9'd1;
      end else begin
        col <= col + 8'd1;
      end
    end
  end

  logic       col_ge;
  logic [9:0] line;
  logic [8:0] wrap_pos;
  logic [7:0] pos;
  logic       active;
  logic [2:0] pat;

  assign col_ge   = (col >= col0);
  assign line     = {1'b0, row} - {1'b0, row0} - {9'd0, ~col_ge};
  assign wrap_pos = {1'b0, col} + {1'b0, per_m1} + 9'd1 - {1'b0, col0};
  assign pos      = col_ge ? (col - col0) : wrap_pos[7:0];
  assign active   = (cnt >= start) && (line < 10'(LINES)) && (pos < 8'(ACTIVE));
  assign pat      = (pos[2:0] == 3'd7) ? 3'd0 : 3'd6 - pos[2:0];

  logic hit, con_d;
  assign hit   = (addr[15:14] == 2'b01) || (!early && addr[15:14] == 2'b11 && bank[0]);
  assign con_d = hit && (!gate || mreq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      contended <= 1'b0;
      wait_ts   <= 3'd0;
    end else begin
      contended <= con_d;
      wait_ts   <= (con_d && active) ? pat : 3'd0;
    end
  end

  assign tstate      = cnt;
  assign frame_start = (cnt == 17'd0);

  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (cnt == len_m1) |=> (tstate == 17'd0)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (cnt != len_m1) |=> (tstate == $past(cnt) + 17'd1)); // R1
  AST_EARLY_UPPER: assert property (@(posedge clk) disable iff (!rst_n) (early && addr[15]) |=> !contended); // R3
  AST_GATE_MREQ: assert property (@(posedge clk) disable iff (!rst_n) (gate && !mreq) |=> (!contended && wait_ts == 3'd0)); // R4
  AST_WAIT_MAX: assert property (@(posedge clk) disable iff (!rst_n) wait_ts <= 3'd6); // R5
  AST_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n) (cnt < start) |=> (wait_ts == 3'd0)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !contended |-> (wait_ts == 3'd0)); // R9
endmodule

// File: tb/vid_contention_test.sv
module vid_contention_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [1:0]  mode;
  logic [15:0] addr;
  logic [2:0]  bank;
  logic        mreq;
  logic [16:0] tstate, tstate_a;
  logic        frame_start, frame_start_a;
  logic        contended, contended_a;
  logic [2:0]  wait_ts, wait_ts_a;

  vid_contention uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .bank(bank), .mreq(mreq),
    .tstate(tstate), .frame_start(frame_start), .contended(contended), .wait_ts(wait_ts));

  vid_contention #(.LATE_START(1'b1)) uut_alt (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .bank(bank), .mreq(mreq),
    .tstate(tstate_a), .frame_start(frame_start_a), .contended(contended_a), .wait_ts(wait_ts_a));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d tstate=%0d mode=%0d", req, what, act, exp, tstate, mode);
    end
  endtask

  function automatic int ref_wait(int t, int m, bit late, logic [15:0] a, logic [2:0] b, bit rq,
                                  output bit con);
    int s, p, d, q;
    con = (a[15:14] == 2'b01) || (m != 0 && a[15:14] == 2'b11 && b[0]);
    if (m >= 2 && !rq) con = 0;
    if (!con) return 0;
    s = (m == 0) ? 14335 + int'(late) : 14361;
    p = (m == 0) ? 224 : 228;
    if (t < s) return 0;
    d = t - s;
    if (d / p >= 192) return 0;
    q = d % p;
    if (q >= 128) return 0;
    q = q % 8;
    return (q < 6) ? 6 - q : 0;
  endfunction

  task automatic sweep(int m, int ncyc);
    int t, len, ew, ewa;
    bit ec, eca;
    len = (m == 0) ? 69888 : 70908;
    rst_n = 1'b0;
    mode = 2'(m);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", int'(tstate), 0, "reset tstate");
    chk("R8", int'(contended), 0, "reset contended");
    chk("R8", int'(wait_ts), 0, "reset wait");
    rst_n = 1'b1;
    t = 0; ew = 0; ewa = 0; ec = 0; eca = 0;
    for (int i = 0; i < ncyc; i++) begin
      chk("R1", int'(tstate), t, "tstate");
      chk("R2", int'(frame_start), (t == 0) ? 1 : 0, "frame_start");
      chk("R3_R4", int'(contended), int'(ec), "contended");
      chk("R5_R6_R7", int'(wait_ts), ew, "wait");
      chk("R6_late", int'(wait_ts_a), ewa, "wait alt start");
      chk("R3_late", int'(contended_a), int'(eca), "contended alt");
      if (contended == 1'b0) chk("R9", int'(wait_ts), 0, "wait when idle");
      addr = 16'($urandom);
      bank = 3'($urandom);
      mreq = 1'($urandom);
      ew  = ref_wait(t, m, 1'b0, addr, bank, mreq, ec);
      ewa = ref_wait(t, m, 1'b1, addr, bank, mreq, eca);
      t = (t + 1) % len;
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; mode = 2'b00; addr = '0; bank = '0; mreq = 1'b0;
    @(negedge clk);
    sweep(0, 69888 + 10);
    sweep(1, 70908 + 10);
    sweep(2, 30000);
    sweep(3, 2000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule